// File: doc/BRIEF.md
# Amplifier Control Mode Resolver

This block turns the raw control sources of a boosted piezo and speaker driver into one consistent set of effective controls. A strap pin chooses between pin control and register control. Under pin control, two dual-purpose pins pick the input, the boost state and the gain step. Under register control, fields written over the serial bus supply the power, input, boost, gain, limiter and dynamics settings. A shutdown pin overrides both paths.

Every resolved control leaves the block through a register. A wake-up timer runs whenever the amplifier is enabled and raises a ready flag once the selected turn-on time has passed. The clock frequency is a parameter, so the slow and fast turn-on times are held as cycle counts derived from it.

Top module: `ctl_mode_resolve`

## Requirements
- R1: With `mode_sw`=0, `in_sel` follows `pin_sel`, and `boost_en` equals `pin_sel` while `shdn_n`=1.
- R2: With `mode_sw`=0, `gain_idx` is 0 (0 dB) or 1 (6 dB) for `pin_sel`=0 and `pin_gain`=0/1. It is 5 (24 dB) or 7 (30 dB) for `pin_sel`=1 and `pin_gain`=0/1.
- R3: With `mode_sw`=1, the power field bits are used as follows. Bit 0 is the enable, so `amp_en` = `shdn_n` AND bit 0. Bit 1 requests boost, so `boost_en` = `amp_en` AND bit 1. Bit 2 gives `in_sel`. Bit 3 selects the fast turn-on.
- R4: With `mode_sw`=1, `gain_idx` = {power bit 1, gain field[1:0]}. Index 0..3 stands for 0/6/12/18 dB and 4..7 for 21/24/27/30 dB.
- R5: `lim_en` is 1 only when `mode_sw`=1, `boost_en`=1 and the limit code (limit field bits 2:0) is active. `lim_code` repeats that code while `lim_en`=1 and reads 0 otherwise.
- R6: Limit codes 000 and 111 both leave `lim_en`=0. Codes 001..110 enable the limiter.
- R7: With `mode_sw`=1, `atk_code` = limit field bits 4:3 and `rel_code` = limit field bits 6:5. With `mode_sw`=0, both read 0 and `lim_en` is 0.
- R8: `shdn_n`=0 forces `amp_en`, `boost_en` and `lim_en` to 0 in either mode.
- R9: `wake_ready` rises on the WAKE_SLOW-th rising edge after the enable is applied. WAKE_SLOW is CLK_HZ*15/1000 cycles. It rises on the WAKE_FAST-th edge (CLK_HZ*5/1000 cycles) instead when `mode_sw`=1 and power bit 3 = 1. Pin mode always uses the slow time.
- R10: `wake_ready` falls on the same edge as `amp_en` falls. Each new enable restarts the full count.
- R11: Every output changes on the first rising edge after its inputs change, and all outputs are 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sw | input | 1 | 1 = register control, 0 = pin control |
| pin_sel | input | 1 | Pin mode input/boost select |
| pin_gain | input | 1 | Pin mode gain step select |
| shdn_n | input | 1 | Shutdown pin, low disables |
| reg_pwr | input | 4 | Power field: fast turn-on, input, boost, enable (bit 3..0) |
| reg_lim | input | 7 | Limit field: release[6:5], attack[4:3], limit code[2:0] |
| reg_gain | input | 2 | Register gain step |
| amp_en | output | 1 | Effective amplifier enable |
| boost_en | output | 1 | Effective boost enable |
| in_sel | output | 1 | Effective input select (0 = input 1) |
| gain_idx | output | 3 | Effective gain index |
| lim_en | output | 1 | Voltage limiter enable |
| lim_code | output | 3 | Active limit threshold code |
| atk_code | output | 2 | Attack time code |
| rel_code | output | 2 | Release time code |
| wake_ready | output | 1 | Turn-on time elapsed |

## Verification
All decoded controls are due exactly one rising edge after the inputs change. The bench drives on the falling edge and samples 1 ns after the next rising edge, so each result is read in the cycle it first appears. For R11 it also samples just before that edge to confirm the old value is still present. The ready flag is due N edges after the enable, where N is the slow or fast count. The bench counts N-1 edges and confirms the flag is still low, then takes one more edge and confirms it is high. It repeats this count after a shutdown pulse.

// File: rtl/ctlres_pkg.sv
package ctlres_pkg;
  localparam int GAIN_W = 3;
  localparam int LIM_W  = 3;
  localparam int DYN_W  = 2;

  typedef struct packed {
    logic              amp_en;
    logic              boost_en;
    logic              in_sel;
    logic [GAIN_W-1:0] gain_idx;
    logic              lim_en;
    logic [LIM_W-1:0]  lim_code;
    logic [DYN_W-1:0]  atk_code;
    logic [DYN_W-1:0]  rel_code;
    logic              fast_wake;
  } ctl_t;

  function automatic logic lim_active(input logic [LIM_W-1:0] code);
    return (code != '0) && (code != '1);
  endfunction
endpackage

// File: rtl/ctlres_decode.sv
module ctlres_decode
  import ctlres_pkg::*;
(
  input  logic                 mode_sw,
  input  logic                 pin_sel,
  input  logic                 pin_gain,
  input  logic                 shdn_n,
  input  logic [3:0]           reg_pwr,
  input  logic [6:0]           reg_lim,
  input  logic [1:0]           reg_gain,
  output ctl_t                 ctl
);
  logic boost_req;
  logic amp_on;
  logic [LIM_W-1:0] code;

  always_comb begin
    code      = reg_lim[LIM_W-1:0];
    boost_req = mode_sw ? reg_pwr[1] : pin_sel;
    amp_on    = shdn_n & (mode_sw ? reg_pwr[0] : 1'b1);

    ctl           = '0;
    ctl.amp_en    = amp_on;
    ctl.boost_en  = amp_on & boost_req;
    ctl.in_sel    = mode_sw ? reg_pwr[2] : pin_sel;
    ctl.fast_wake = mode_sw & reg_pwr[3];
    if (mode_sw) begin
      ctl.gain_idx = {boost_req, reg_gain};
      ctl.atk_code = reg_lim[4:3];
      ctl.rel_code = reg_lim[6:5];
      ctl.lim_en   = amp_on & boost_req & lim_active(code);
      ctl.lim_code = ctl.lim_en ? code : '0;
    end else begin
      // pin mode: input 1 -> 0/6 dB (idx 0/1), input 2 -> 24/30 dB (idx 5/7)
      ctl.gain_idx = pin_sel ? {2'b10, 1'b1} | {1'b0, pin_gain, 1'b0}
                             : {2'b00, pin_gain};
    end
  end
endmodule

// File: rtl/ctlres_wake.sv
module ctlres_wake #(
  parameter int SLOW_CYC = 3000,
  parameter int FAST_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic fast,
  output logic ready
);
  localparam int CNT_W = $clog2(SLOW_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, last_cnt;
  logic             rdy_q, rdy_d;

  always_comb begin
    last_cnt = fast ? CNT_W'(FAST_CYC - 1) : CNT_W'(SLOW_CYC - 1);
    cnt_d    = cnt_q;
    rdy_d    = rdy_q;
    if (!en) begin
      cnt_d = '0;
      rdy_d = 1'b0;
    end else if (!rdy_q) begin
      if (cnt_q == last_cnt) begin
        rdy_d = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign ready = rdy_q;

  // R10: a disable always clears ready on the next edge
  a_r10_drop_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !rdy_q);
  // R9: ready cannot appear while the counter is still mid-count from zero
  a_r9_no_early_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !rdy_q && cnt_q == '0) |=> !rdy_q);
endmodule

// File: rtl/ctl_mode_resolve.sv
module ctl_mode_resolve
  import ctlres_pkg::*;
#(
  parameter int CLK_HZ  = 200_000_000,
  parameter int SLOW_MS = 15,
  parameter int FAST_MS = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_sw,
  input  logic       pin_sel,
  input  logic       pin_gain,
  input  logic       shdn_n,
  input  logic [3:0] reg_pwr,
  input  logic [6:0] reg_lim,
  input  logic [1:0] reg_gain,
  output logic       amp_en,
  output logic       boost_en,
  output logic       in_sel,
  output logic [2:0] gain_idx,
  output logic       lim_en,
  output logic [2:0] lim_code,
  output logic [1:0] atk_code,
  output logic [1:0] rel_code,
  output logic       wake_ready
);
  localparam int WAKE_SLOW = (CLK_HZ / 1000) * SLOW_MS;
  localparam int WAKE_FAST = (CLK_HZ / 1000) * FAST_MS;

  ctl_t ctl_d, ctl_q;

  ctlres_decode u_dec (
    .mode_sw (mode_sw),
    .pin_sel (pin_sel),
    .pin_gain(pin_gain),
    .shdn_n  (shdn_n),
    .reg_pwr (reg_pwr),
    .reg_lim (reg_lim),
    .reg_gain(reg_gain),
    .ctl     (ctl_d)
  );

  ctlres_wake #(.SLOW_CYC(WAKE_SLOW), .FAST_CYC(WAKE_FAST)) u_wake (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (ctl_d.amp_en),
    .fast (ctl_d.fast_wake),
    .ready(wake_ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign amp_en   = ctl_q.amp_en;
  assign boost_en = ctl_q.boost_en;
  assign in_sel   = ctl_q.in_sel;
  assign gain_idx = ctl_q.gain_idx;
  assign lim_en   = ctl_q.lim_en;
  assign lim_code = ctl_q.lim_code;
  assign atk_code = ctl_q.atk_code;
  assign rel_code = ctl_q.rel_code;

  // R8: boost never runs without the amplifier
  a_r8_boost_needs_amp: assert property (@(posedge clk) disable iff (!rst_n)
    !amp_en |-> !boost_en);
  // R5: limiter only with boost
  a_r5_lim_needs_boost: assert property (@(posedge clk) disable iff (!rst_n)
    lim_en |-> boost_en);
  // R6: an enabled limiter never carries a disabling code
  a_r6_lim_code_valid: assert property (@(posedge clk) disable iff (!rst_n)
    lim_en |-> (lim_code != 3'b000 && lim_code != 3'b111));
  // R4: boosted operation always lands in the upper gain half
  a_r4_boost_gain_high: assert property (@(posedge clk) disable iff (!rst_n)
    boost_en |-> gain_idx[2]);
  // R7: pin mode yields no limiter and no dynamics codes
  a_r7_hw_no_alc: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_sw |=> (!lim_en && atk_code == 2'b00 && rel_code == 2'b00));
  // R10: ready only while enabled
  a_r10_ready_needs_amp: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ready |-> amp_en);
endmodule

// File: tb/sim_ctl_mode_resolve.sv
`timescale 1ns/1ps
module sim_ctl_mode_resolve;
  localparam int CLK_HZ = 200_000;
  localparam int SLOW = (CLK_HZ / 1000) * 15;
  localparam int FAST = (CLK_HZ / 1000) * 5;

  logic clk = 1'b0;
  logic rst_n;
  logic mode_sw, pin_sel, pin_gain, shdn_n;
  logic [3:0] reg_pwr;
  logic [6:0] reg_lim;
  logic [1:0] reg_gain;
  logic amp_en, boost_en, in_sel, lim_en, wake_ready;
  logic [2:0] gain_idx, lim_code;
  logic [1:0] atk_code, rel_code;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ctl_mode_resolve #(.CLK_HZ(CLK_HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_sw(mode_sw), .pin_sel(pin_sel),
    .pin_gain(pin_gain), .shdn_n(shdn_n), .reg_pwr(reg_pwr), .reg_lim(reg_lim),
    .reg_gain(reg_gain), .amp_en(amp_en), .boost_en(boost_en), .in_sel(in_sel),
    .gain_idx(gain_idx), .lim_en(lim_en), .lim_code(lim_code),
    .atk_code(atk_code), .rel_code(rel_code), .wake_ready(wake_ready)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive on falling edge, sample just after the following rising edge
  task automatic apply(input logic m, input logic s, input logic g, input logic sd,
                       input logic [3:0] p, input logic [6:0] l, input logic [1:0] gn);
    @(negedge clk);
    mode_sw = m; pin_sel = s; pin_gain = g; shdn_n = sd;
    reg_pwr = p; reg_lim = l; reg_gain = gn;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; mode_sw = 1'b1; pin_sel = 1'b1; pin_gain = 1'b1; shdn_n = 1'b1;
    reg_pwr = 4'hF; reg_lim = 7'h7F; reg_gain = 2'b11;
    repeat (3) @(posedge clk); #1;
    chk("R11 reset amp_en", amp_en, 0);
    chk("R11 reset gain_idx", gain_idx, 0);
    chk("R11 reset wake_ready", wake_ready, 0);
    chk("R11 reset atk_code", atk_code, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_hw_modes;
    for (int s = 0; s < 2; s++)
      for (int g = 0; g < 2; g++) begin
        apply(1'b0, s[0], g[0], 1'b1, 4'h0, 7'b1111011, 2'b00);
        chk("R1 hw in_sel", in_sel, s);
        chk("R1 hw boost_en", boost_en, s);
        chk("R2 hw gain_idx", gain_idx, (s == 0) ? g : (g ? 7 : 5));
        chk("R7 hw lim_en", lim_en, 0);
        chk("R7 hw atk_code", atk_code, 0);
        chk("R7 hw rel_code", rel_code, 0);
      end
  endtask

  task automatic t_sw_power;
    for (int p = 0; p < 8; p++) begin
      apply(1'b1, 1'b0, 1'b0, 1'b1, {1'b0, p[2:0]}, 7'h00, 2'b00);
      chk("R3 sw amp_en", amp_en, p[0]);
      chk("R3 sw boost_en", boost_en, p[0] & p[1]);
      chk("R3 sw in_sel", in_sel, p[2]);
    end
  endtask

  task automatic t_sw_gain;
    for (int b = 0; b < 2; b++)
      for (int g = 0; g < 4; g++) begin
        apply(1'b1, 1'b0, 1'b0, 1'b1, {2'b00, b[0], 1'b1}, 7'h00, g[1:0]);
        chk("R4 sw gain_idx", gain_idx, b * 4 + g);
      end
  endtask

  task automatic t_limiter;
    for (int c = 0; c < 8; c++) begin
      apply(1'b1, 1'b0, 1'b0, 1'b1, 4'b0011, {4'b0000, c[2:0]}, 2'b00);
      chk("R6 lim_en per code", lim_en, (c != 0 && c != 7) ? 1 : 0);
      chk("R5 lim_code echo", lim_code, (c != 0 && c != 7) ? c : 0);
    end
    apply(1'b1, 1'b0, 1'b0, 1'b1, 4'b0001, 7'b0000011, 2'b00);
    chk("R5 lim_en without boost", lim_en, 0);
    chk("R5 lim_code without boost", lim_code, 0);
  endtask

  task automatic t_alc_codes;
    for (int a = 0; a < 4; a++) begin
      apply(1'b1, 1'b0, 1'b0, 1'b1, 4'b0011, {a[1:0], ~a[1:0], 3'b010}, 2'b00);
      chk("R7 sw atk_code", atk_code, (~a) & 3);
      chk("R7 sw rel_code", rel_code, a);
    end
  endtask

  task automatic t_shutdown;
    apply(1'b1, 1'b0, 1'b0, 1'b0, 4'b0011, 7'b0000010, 2'b00);
    chk("R8 sw amp_en", amp_en, 0);
    chk("R8 sw boost_en", boost_en, 0);
    chk("R8 sw lim_en", lim_en, 0);
    apply(1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 7'h00, 2'b00);
    chk("R8 hw amp_en", amp_en, 0);
    chk("R8 hw boost_en", boost_en, 0);
  endtask

  task automatic t_registered;
    apply(1'b1, 1'b0, 1'b0, 1'b1, 4'b0001, 7'h00, 2'b00);
    @(negedge clk);
    reg_gain = 2'b10;
    @(posedge clk); #0;
    chk("R11 before edge", gain_idx, 0);
    #1;
    chk("R11 after edge", gain_idx, 2);
  endtask

  task automatic wake_run(input string req, input int n);
    repeat (n - 2) @(posedge clk);
    #1;
    chk({req, " not yet ready"}, wake_ready, 0);
    @(posedge clk); #1;
    chk({req, " ready"}, wake_ready, 1);
  endtask

  task automatic t_wake;
    apply(1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 7'h00, 2'b00);
    apply(1'b0, 1'b0, 1'b0, 1'b1, 4'h0, 7'h00, 2'b00);  // edge 1
    chk("R9 slow amp_en", amp_en, 1);
    wake_run("R9 slow hw", SLOW);
    apply(1'b1, 1'b0, 1'b0, 1'b0, 4'b1001, 7'h00, 2'b00);
    chk("R10 ready drop", wake_ready, 0);
    chk("R10 amp drop", amp_en, 0);
    apply(1'b1, 1'b0, 1'b0, 1'b1, 4'b1001, 7'h00, 2'b00);
    wake_run("R9 fast sw", FAST);
    apply(1'b1, 1'b0, 1'b0, 1'b1, 4'b1000, 7'h00, 2'b00);
    chk("R10 reg disable", wake_ready, 0);
    apply(1'b1, 1'b0, 1'b0, 1'b1, 4'b1001, 7'h00, 2'b00);
    wake_run("R10 restart", FAST);
  endtask

  initial begin
    #200_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_hw_modes();
    t_sw_power();
    t_sw_gain();
    t_limiter();
    t_alc_codes();
    t_shutdown();
    t_registered();
    t_wake();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule